// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the D+/D- pair. A start strobe launches either a data packet or a handshake reply. A data packet takes its bytes from an external buffer through a read port. A handshake reply sends a single PID byte that is supplied with the strobe. The block sends the sync byte first. It then NRZI-encodes every byte least significant bit first and inserts stuff bits. It closes with an end-of-packet sequence and then lets go of the pair.

Each bit lasts a whole number of system clocks, set by a parameter. The pins are set to the idle J level one cycle before the output enable rises. In the cycle where the bus is released, a new device address is adopted, but only if the packet just sent carried data.

Top module: `lsusb_tx`

## Requirements
- R1: After reset, `busy`, `done` and `oe` are low, `dp` and `dm` are low, and `dev_addr` is zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. For exactly that one cycle `oe` stays low and the pins show J (`dp`=0, `dm`=1). `oe` rises on the following cycle.
- R3: The serial stream begins with the sync byte 0x80. Every byte is sent least significant bit first. In data mode the packet holds `pkt_len` bytes including sync (valid range 2 to 12). The non-sync bytes are taken from `rd_data` while `rd_addr` counts 0, 1, 2 and so on.
- R4: NRZI coding is used. A 0 bit flips the line and a 1 bit holds it. K is `dp`=1 and `dm`=0, and J is `dp`=0 and `dm`=1. The line is J before the first bit.
- R5: After six 1 bits in a row, one extra 0 bit is sent. This also applies when the sixth 1 is the last data bit, in which case the extra bit comes before the end of packet.
- R6: Every line bit, stuff bits included, is held for exactly `CLKS_PER_BIT` clock cycles.
- R7: After the last bit, both pins are low (SE0) for 2 bit times. The pins then show J for 1 bit time. After that `oe` falls and both pins are low.
- R8: `done` is high for exactly the one cycle in which `oe` falls. `busy` is low in that same cycle.
- R9: With `hs_mode` high at start, the packet is the sync byte followed by `hs_pid`, whatever the value of `pkt_len`.
- R10: `dev_addr` takes the value of `pend_addr` in the release cycle of a data packet. It is left unchanged after a handshake and never changes at any other time.
- R11: A `start` raised while `busy` is high is ignored. The packet in flight is unchanged and no second packet follows.
- R12: While `oe` is high, `dp` and `dm` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| hs_mode | input | 1 | 1: send a handshake PID, 0: send a data packet |
| hs_pid | input | 8 | PID byte for handshake mode |
| pkt_len | input | LEN_W | Bytes in a data packet including sync |
| rd_addr | output | LEN_W | Buffer index of the next byte |
| rd_data | input | 8 | Buffer byte at `rd_addr` (combinational read) |
| pend_addr | input | ADDR_W | Device address waiting to be adopted |
| dev_addr | output | ADDR_W | Active device address |
| busy | output | 1 | High from acceptance of start until release |
| done | output | 1 | One-cycle pulse at bus release |
| dp | output | 1 | D+ level |
| dm | output | 1 | D- level |
| oe | output | 1 | Output enable for both pins |

## Verification
The hardest case is a stuff bit that falls exactly where a byte ends. This includes the case where the stuff bit lands after the final data bit, right before SE0. In that case the stuff decision has to take priority over both loading the next byte and entering end of packet. The sweep covers every packet length from 2 to 12. It uses byte patterns of all ones and alternating 0x7E/0xFC, so runs of six ones end at byte boundaries and at the packet's tail. A start strobe injected in the middle of a packet checks that a request is ignored while busy.

// File: rtl/lsusb_tx.sv
module lsusb_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int LEN_W        = 4,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic [7:0]        hs_pid,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic [LEN_W-1:0]  rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              busy,
  output logic              done,
  output logic              dp,
  output logic              dm,
  output logic              oe
);

  localparam int CW = $clog2(2 * CLKS_PER_BIT) + 1;
  localparam logic [CW-1:0] BIT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] SE0_LAST = CW'(2 * CLKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DATA, S_SE0, S_EOPJ} st_t;

  st_t              st;
  logic [CW-1:0]    ctr;
  logic [7:0]       sh;
  logic [2:0]       bi;
  logic [2:0]       ones;
  logic [LEN_W-1:0] rem;
  logic             have;
  logic             hs_q;
  logic [7:0]       pid_q;

  wire bnd   = (st == S_PRE) || (st == S_DATA && ctr == BIT_LAST);
  wire stuff = (ones == 3'd6);
  wire [7:0] nxt_byte = hs_q ? pid_q : rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ctr      <= '0;
      sh       <= '0;
      bi       <= '0;
      ones     <= '0;
      rem      <= '0;
      have     <= 1'b0;
      hs_q     <= 1'b0;
      pid_q    <= '0;
      rd_addr  <= '0;
      dev_addr <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dp       <= 1'b0;
      dm       <= 1'b0;
      oe       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st      <= S_PRE;
            busy    <= 1'b1;
            dp      <= 1'b0;
            dm      <= 1'b1;
            hs_q    <= hs_mode;
            pid_q   <= hs_pid;
            rem     <= hs_mode ? LEN_W'(1) : pkt_len - LEN_W'(1);
            sh      <= 8'h80;
            bi      <= '0;
            ones    <= '0;
            have    <= 1'b1;
            rd_addr <= '0;
            ctr     <= '0;
          end
        end
        S_PRE, S_DATA: begin
          if (!bnd) begin
            ctr <= ctr + 1'b1;
          end else begin
            ctr <= '0;
            st  <= S_DATA;
            oe  <= 1'b1;
            if (stuff) begin
              ones <= '0;
              dp   <= ~dp;
              dm   <= ~dm;
            end else if (have) begin
              if (sh[0]) begin
                ones <= ones + 1'b1;
              end else begin
                ones <= '0;
                dp   <= ~dp;
                dm   <= ~dm;
              end
              if (bi == 3'd7) begin
                if (rem != '0) begin
                  sh      <= nxt_byte;
                  rem     <= rem - 1'b1;
                  rd_addr <= rd_addr + 1'b1;
                  bi      <= '0;
                end else begin
                  have <= 1'b0;
                end
              end else begin
                sh <= {1'b0, sh[7:1]};
                bi <= bi + 1'b1;
              end
            end else begin
              st <= S_SE0;
              dp <= 1'b0;
              dm <= 1'b0;
            end
          end
        end
        S_SE0: begin
          if (ctr == SE0_LAST) begin
            st  <= S_EOPJ;
            ctr <= '0;
            dp  <= 1'b0;
            dm  <= 1'b1;
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        S_EOPJ: begin
          if (ctr == BIT_LAST) begin
            st   <= S_IDLE;
            ctr  <= '0;
            oe   <= 1'b0;
            dp   <= 1'b0;
            dm   <= 1'b0;
            busy <= 1'b0;
            done <= 1'b1;
            if (!hs_q) dev_addr <= pend_addr;
          end else begin
            ctr <= ctr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              busy,
  input logic              done,
  input logic              dp,
  input logic              dm,
  input logic              oe
);

  p_oe_needs_j_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> ($past(dp) == 1'b0 && $past(dm) == 1'b1 && busy));

  p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !oe));

  p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (done && !dp && !dm));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !oe));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_addr_only_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> done);

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && oe) |=> (busy || done));

  p_no_se1_r12: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !(dp && dm));

endmodule

bind lsusb_tx lsusb_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
  .busy(busy), .done(done), .dp(dp), .dm(dm), .oe(oe)
);

// File: tb/lsusb_tx_tb.sv
module lsusb_tx_tb;
  localparam int C  = 4;
  localparam int LW = 4;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic hs_mode = 1'b0;
  logic [7:0] hs_pid = '0;
  logic [LW-1:0] pkt_len = '0;
  logic [LW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic [AW-1:0] pend_addr = '0;
  logic [AW-1:0] dev_addr;
  logic busy, done, dp, dm, oe;

  logic [7:0] mem [0:15];
  assign rd_data = mem[rd_addr];

  always #2 clk = ~clk;

  lsusb_tx #(.CLKS_PER_BIT(C), .LEN_W(LW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_pid(hs_pid),
    .pkt_len(pkt_len), .rd_addr(rd_addr), .rd_data(rd_data), .pend_addr(pend_addr),
    .dev_addr(dev_addr), .busy(busy), .done(done), .dp(dp), .dm(dm), .oe(oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] exp_addr = '0;
  bit exp_k [0:255];
  int nb;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input bit hs, input int len, input logic [7:0] pid);
    bit line = 0;
    int ones = 0;
    int nbytes = hs ? 2 : len;
    nb = 0;
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b = (i == 0) ? 8'h80 : (hs ? pid : mem[i-1]);
      for (int j = 0; j < 8; j++) begin
        if (b[j]) ones++;
        else begin ones = 0; line = ~line; end
        exp_k[nb] = line; nb++;
        if (ones == 6) begin
          line = ~line; ones = 0;
          exp_k[nb] = line; nb++;
        end
      end
    end
  endtask

  task automatic run_pkt(input bit hs, input int len, input logic [7:0] pid,
                         input logic [AW-1:0] pa, input bit inject);
    int total;
    build(hs, len, pid);
    @(negedge clk);
    start = 1'b1; hs_mode = hs; hs_pid = pid; pkt_len = LW'(len); pend_addr = pa;
    @(negedge clk);
    start = 1'b0;
    // R2: one cycle of J preset with oe low
    check(busy && !oe && !dp && dm, "R2", {busy, oe, dp, dm}, 4'b1001);
    total = (nb + 3) * C;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (inject && k == 5) begin
        start = 1'b1; hs_mode = ~hs; pkt_len = LW'(2); hs_pid = 8'h0F;
      end else begin
        start = 1'b0;
      end
      if (k < nb * C) begin
        // R3 R4 R5 R6 R9: line level per cycle of every bit
        check(oe && dp == exp_k[k / C] && dm == !exp_k[k / C],
              hs ? "R9/R4/R5/R6" : "R3/R4/R5/R6", {oe, dp, dm}, {1'b1, exp_k[k / C], !exp_k[k / C]});
      end else if (k < (nb + 2) * C) begin
        check(oe && !dp && !dm && busy, "R7 se0", {oe, dp, dm}, 3'b100);
      end else begin
        check(oe && !dp && dm && !done, "R7 j", {oe, dp, dm, done}, 4'b1010);
      end
    end
    start = 1'b0;
    @(negedge clk);
    if (!hs) exp_addr = pa;
    check(!oe && !dp && !dm, "R7 release", {oe, dp, dm}, 3'b000);
    check(done && !busy, "R8", {done, busy}, 2'b10);
    check(dev_addr == exp_addr, "R10", dev_addr, exp_addr);
    @(negedge clk);
    check(!done, "R8 pulse", done, 0);
    repeat (2 * C) begin
      @(negedge clk);
      check(!busy && !oe, "R11", {busy, oe}, 2'b00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !oe && !dp && !dm && dev_addr == 0, "R1",
          {busy, done, oe, dp, dm}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      for (int len = 2; len <= 12; len++) begin
        for (int i = 0; i < 16; i++) begin
          case (p)
            0: mem[i] = 8'hFF;
            1: mem[i] = 8'h00;
            2: mem[i] = 8'(i * 37 + len);
            default: mem[i] = (i % 2) ? 8'hFC : 8'h7E;
          endcase
        end
        run_pkt(1'b0, len, 8'h00, AW'(len * 5 + p), 1'b0);
      end
    end
    // R9 R10: handshakes keep the address
    run_pkt(1'b1, 9, 8'hD2, 7'h55, 1'b0);
    run_pkt(1'b1, 3, 8'h5A, 7'h2A, 1'b0);
    run_pkt(1'b1, 2, 8'hFF, 7'h11, 1'b0);
    // R11: start during busy
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'hA5 ^ i);
    run_pkt(1'b0, 6, 8'h00, 7'h3C, 1'b1);
    run_pkt(1'b1, 4, 8'h5A, 7'h01, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule